// File: doc/BRIEF.md
# SPI Master Interrupt Status and Mask Block

This block gathers the interrupt sources of a byte-oriented SPI master into one seven-bit status word, gates them with a mask, and drives a single level-sensitive interrupt line. Three sources are event latches. The transmit-underflow, receive-overflow and mode-fault strobes each arrive as single-cycle pulses from the datapath. Each pulse sets its bit, and software clears that bit by writing a 1 to it. The other four sources are not stored. They are evaluated every cycle from the FIFO fill levels and full flags that come in on plain input ports, and from two programmable threshold registers.

Software works through a small word-addressed register port. The write strobe and the write data act on the rising clock edge. Read data is combinational from the address. The mask can be changed only through a set register and a clear register, and it reads back from its own read-only location. Address map: 0 status, 1 mask-set, 2 mask-clear, 3 mask, 4 receive threshold, 5 transmit threshold.

Top module: `spi_irq_ctrl`

## Requirements
- R1: Status bit layout, which the bench relies on: bit 6 transmit underflow, bit 5 receive full, bit 4 receive level reached, bit 3 transmit full, bit 2 transmit room, bit 1 mode fault, bit 0 receive overflow. Status bits 31..7 and every unmapped address (6, 7 and above) read as zero, and writes to unmapped addresses change nothing.
- R2: A pulse on an event input sets its status bit (6, 1 or 0) at the next clock edge. The bit stays set until software clears it.
- R3: Writing the status address clears each sticky bit whose data bit is 1. Data bits of 0, and data bits over the four computed positions, have no effect.
- R4: When an event and a clear of the same sticky bit fall in the same cycle, the bit ends up set.
- R5: Status bit 4 is 1 exactly when the receive level is greater than or equal to the receive threshold.
- R6: Status bit 2 is 1 exactly when the transmit level is strictly less than the transmit threshold.
- R7: Status bits 5 and 3 follow the receive-full and transmit-full inputs in the same cycle.
- R8: Writing address 1 ORs data bits 6..0 into the mask. Address 1 reads as zero.
- R9: Writing address 2 clears the mask bits where data bits 6..0 are 1. Address 2 reads as zero.
- R10: The mask at address 3 is read-only. Writing it leaves the mask unchanged.
- R11: The interrupt output is a register. At each clock edge it takes the OR of (mask AND status) as they stood before that edge.
- R12: After reset both thresholds read 1, and the mask, the sticky bits and the interrupt output are 0. Thresholds are written from data bits LW-1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| rx_level | input | 6 | Receive FIFO fill count |
| tx_level | input | 6 | Transmit FIFO fill count |
| rx_full | input | 1 | Receive FIFO full flag |
| tx_full | input | 1 | Transmit FIFO full flag |
| ev_tx_under | input | 1 | Transmit underflow pulse |
| ev_rx_over | input | 1 | Receive overflow pulse |
| ev_mode_fault | input | 1 | Mode fault pulse |
| irq | output | 1 | Level interrupt request |

## Verification
Each result has its own due cycle, and the bench checks it there.

- **Computed bits and register reads:** the four computed status bits and all register reads are combinational. They are due in the same cycle as the inputs, so the bench compares reg_rdata between driving the inputs and the next rising edge.
- **Sticky bits, mask and thresholds:** these are due one edge after the event or write that changes them.
- **Interrupt output:** irq lags the masked status by one more register. The bench predicts it from its model state before the edge and compares it just after that edge.

A seeded random phase mixes events, writes and levels. Directed cases cover the reset state, event-versus-clear collisions, zero thresholds and writes to the read-only mask.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;
   localparam int ST_W = 7;

   // status bit positions (software decodes these)
   localparam int B_TX_UNDER = 6;
   localparam int B_RX_FULL  = 5;
   localparam int B_RX_READY = 4;
   localparam int B_TX_FULL  = 3;
   localparam int B_TX_ROOM  = 2;
   localparam int B_MODE_FLT = 1;
   localparam int B_RX_OVER  = 0;

   // word addresses
   localparam int A_STATUS = 0;
   localparam int A_MSET   = 1;
   localparam int A_MCLR   = 2;
   localparam int A_MASK   = 3;
   localparam int A_RTHR   = 4;
   localparam int A_TTHR   = 5;

   typedef struct packed {
      logic tx_under;
      logic rx_full;
      logic rx_ready;
      logic tx_full;
      logic tx_room;
      logic mode_flt;
      logic rx_over;
   } irq_status_t;
endpackage

// File: rtl/spi_irq_sticky.sv
module spi_irq_sticky #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;   // event has priority over clear
         else if (clr_i[i]) q <= 1'b0;
      end
      assign q_o[i] = q;
   end
endmodule

// File: rtl/spi_irq_level_cmp.sv
module spi_irq_level_cmp #(
   parameter int LW       = 6,
   parameter bit AT_LEAST = 1'b1
) (
   input  logic [LW-1:0] level_i,
   input  logic [LW-1:0] thr_i,
   output logic          hit_o
);
   if (AT_LEAST) begin : g_ge
      assign hit_o = (level_i >= thr_i);
   end else begin : g_lt
      assign hit_o = (level_i < thr_i);
   end
endmodule

// File: rtl/spi_irq_thr_reg.sv
module spi_irq_thr_reg #(
   parameter int LW  = 6,
   parameter int RST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [LW-1:0] d_i,
   output logic [LW-1:0] q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    q_o <= LW'(RST);
      else if (we_i) q_o <= d_i;
   end
endmodule

// File: rtl/spi_irq_mask.sv
module spi_irq_mask #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we_i,
   input  logic         clr_we_i,
   input  logic [N-1:0] bits_i,
   output logic [N-1:0] mask_o
);
   logic [N-1:0] set_v, clr_v;
   assign set_v = set_we_i ? bits_i : '0;
   assign clr_v = clr_we_i ? bits_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_o <= '0;
      else        mask_o <= (mask_o & ~clr_v) | set_v;
   end
endmodule

// File: rtl/spi_irq_ctrl.sv
module spi_irq_ctrl
   import spi_irq_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 4,
   parameter int RX_DEPTH = 32,
   parameter int TX_DEPTH = 32
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic [ADDR_W-1:0]               reg_addr,
   input  logic [DATA_W-1:0]               reg_wdata,
   output logic [DATA_W-1:0]               reg_rdata,
   input  logic [$clog2(RX_DEPTH+1)-1:0]   rx_level,
   input  logic [$clog2(TX_DEPTH+1)-1:0]   tx_level,
   input  logic                            rx_full,
   input  logic                            tx_full,
   input  logic                            ev_tx_under,
   input  logic                            ev_rx_over,
   input  logic                            ev_mode_fault,
   output logic                            irq
);
   localparam int RLW = $clog2(RX_DEPTH+1);
   localparam int TLW = $clog2(TX_DEPTH+1);
   localparam int NST = 3;

   // elaboration-time parameter checks
   if (DATA_W < 8 || DATA_W < RLW || DATA_W < TLW) begin : g_bad_data_w
      $error("spi_irq_ctrl: DATA_W too narrow");
   end
   if (ADDR_W < 3) begin : g_bad_addr_w
      $error("spi_irq_ctrl: ADDR_W must cover six registers");
   end
   if (RX_DEPTH < 1 || TX_DEPTH < 1) begin : g_bad_depth
      $error("spi_irq_ctrl: FIFO depths must be positive");
   end

   // address decode
   logic wr_sts, wr_mset, wr_mclr, wr_rthr, wr_tthr;
   assign wr_sts  = reg_wr && (reg_addr == ADDR_W'(A_STATUS));
   assign wr_mset = reg_wr && (reg_addr == ADDR_W'(A_MSET));
   assign wr_mclr = reg_wr && (reg_addr == ADDR_W'(A_MCLR));
   assign wr_rthr = reg_wr && (reg_addr == ADDR_W'(A_RTHR));
   assign wr_tthr = reg_wr && (reg_addr == ADDR_W'(A_TTHR));

   // sticky event latches: index 2 underflow, 1 mode fault, 0 overflow
   logic [NST-1:0] ev_vec, clr_vec, sticky_q;
   assign ev_vec  = {ev_tx_under, ev_mode_fault, ev_rx_over};
   assign clr_vec = wr_sts ? {reg_wdata[B_TX_UNDER], reg_wdata[B_MODE_FLT],
                              reg_wdata[B_RX_OVER]} : '0;

   spi_irq_sticky #(.N(NST)) u_sticky (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (ev_vec),
      .clr_i (clr_vec),
      .q_o   (sticky_q)
   );

   // thresholds
   logic [RLW-1:0] rthr_q;
   logic [TLW-1:0] tthr_q;

   spi_irq_thr_reg #(.LW(RLW), .RST(1)) u_rthr (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_rthr),
      .d_i   (reg_wdata[RLW-1:0]),
      .q_o   (rthr_q)
   );

   spi_irq_thr_reg #(.LW(TLW), .RST(1)) u_tthr (
      .clk   (clk),
      .rst_n (rst_n),
      .we_i  (wr_tthr),
      .d_i   (reg_wdata[TLW-1:0]),
      .q_o   (tthr_q)
   );

   // level comparisons
   logic rx_ready, tx_room;

   spi_irq_level_cmp #(.LW(RLW), .AT_LEAST(1'b1)) u_rx_cmp (
      .level_i (rx_level),
      .thr_i   (rthr_q),
      .hit_o   (rx_ready)
   );

   spi_irq_level_cmp #(.LW(TLW), .AT_LEAST(1'b0)) u_tx_cmp (
      .level_i (tx_level),
      .thr_i   (tthr_q),
      .hit_o   (tx_room)
   );

   // status word
   irq_status_t sts_s;
   logic [ST_W-1:0] sts;
   always_comb begin
      sts_s.tx_under = sticky_q[2];
      sts_s.rx_full  = rx_full;
      sts_s.rx_ready = rx_ready;
      sts_s.tx_full  = tx_full;
      sts_s.tx_room  = tx_room;
      sts_s.mode_flt = sticky_q[1];
      sts_s.rx_over  = sticky_q[0];
   end
   assign sts = sts_s;

   // mask
   logic [ST_W-1:0] mask_q;

   spi_irq_mask #(.N(ST_W)) u_mask (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_we_i (wr_mset),
      .clr_we_i (wr_mclr),
      .bits_i   (reg_wdata[ST_W-1:0]),
      .mask_o   (mask_q)
   );

   // registered interrupt line
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= |(mask_q & sts);
   end

   // read mux
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_STATUS): reg_rdata = DATA_W'(sts);
         ADDR_W'(A_MASK):   reg_rdata = DATA_W'(mask_q);
         ADDR_W'(A_RTHR):   reg_rdata = DATA_W'(rthr_q);
         ADDR_W'(A_TTHR):   reg_rdata = DATA_W'(tthr_q);
         default:           reg_rdata = '0;
      endcase
   end

   wire unused_wdata_hi = ^reg_wdata[DATA_W-1:ST_W];
endmodule

// File: rtl/spi_irq_ctrl_chk.sv
module spi_irq_ctrl_chk #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              ev_tx_under,
   input logic              ev_rx_over,
   input logic              ev_mode_fault,
   input logic              irq,
   input logic [6:0]        mask_q,
   input logic [6:0]        sts
);
   // R2
   under_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_tx_under |=> sts[6]);

   // R4
   fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_mode_fault |=> sts[1]);

   // R3
   w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(0) && reg_wdata[0] && !ev_rx_over) |=> !sts[0]);

   // R8
   mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(1)) |=>
         ((mask_q & $past(reg_wdata[6:0])) == $past(reg_wdata[6:0])));

   // R9
   mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(2)) |=> ((mask_q & $past(reg_wdata[6:0])) == 7'd0));

   // R10
   mask_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(3)) |=> $stable(mask_q));

   // R11
   irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(mask_q & sts))));

   // R1
   sts_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(0)) |-> (reg_rdata[DATA_W-1:7] == '0));
endmodule

bind spi_irq_ctrl spi_irq_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .reg_wr        (reg_wr),
   .reg_addr      (reg_addr),
   .reg_wdata     (reg_wdata),
   .reg_rdata     (reg_rdata),
   .ev_tx_under   (ev_tx_under),
   .ev_rx_over    (ev_rx_over),
   .ev_mode_fault (ev_mode_fault),
   .irq           (irq),
   .mask_q        (mask_q),
   .sts           (sts)
);

// File: tb/spi_irq_ctrl_bench.sv
`timescale 1ns/1ps
module spi_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  rx_level = '0, tx_level = '0;
   logic        rx_full = 1'b0, tx_full = 1'b0;
   logic        ev_tx_under = 1'b0, ev_rx_over = 1'b0, ev_mode_fault = 1'b0;
   logic        irq;

   int n_chk = 0, n_bad = 0;

   // model state
   logic [2:0] m_st;     // {under, fault, over}
   logic [6:0] m_mask;
   logic [5:0] m_rthr, m_tthr;
   logic       m_irq;

   always #2.5 clk = ~clk;

   spi_irq_ctrl u_spi_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_level(rx_level),
      .tx_level(tx_level), .rx_full(rx_full), .tx_full(tx_full),
      .ev_tx_under(ev_tx_under), .ev_rx_over(ev_rx_over),
      .ev_mode_fault(ev_mode_fault), .irq(irq)
   );

   function automatic logic [6:0] exp_status();
      return {m_st[2], rx_full, (rx_level >= m_rthr), tx_full,
              (tx_level < m_tthr), m_st[1], m_st[0]};
   endfunction

   function automatic logic [31:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0: return {25'd0, exp_status()};
         4'd3: return {25'd0, m_mask};
         4'd4: return {26'd0, m_rthr};
         4'd5: return {26'd0, m_tthr};
         default: return 32'd0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // compare read data now, advance one edge with the model, compare irq
   task automatic step(input string req);
      logic [6:0] st;
      #1;
      check(req, reg_rdata, exp_read(reg_addr));
      st = exp_status();
      m_irq = |(m_mask & st);
      if (reg_wr && reg_addr == 4'd0)
         m_st = m_st & ~{reg_wdata[6], reg_wdata[1], reg_wdata[0]};
      m_st = m_st | {ev_tx_under, ev_mode_fault, ev_rx_over};
      if (reg_wr && reg_addr == 4'd1) m_mask = m_mask | reg_wdata[6:0];
      if (reg_wr && reg_addr == 4'd2) m_mask = m_mask & ~reg_wdata[6:0];
      if (reg_wr && reg_addr == 4'd4) m_rthr = reg_wdata[5:0];
      if (reg_wr && reg_addr == 4'd5) m_tthr = reg_wdata[5:0];
      @(posedge clk);
      #1;
      check("R11 irq", {31'd0, irq}, {31'd0, m_irq});
      reg_wr = 1'b0;
      ev_tx_under = 1'b0; ev_rx_over = 1'b0; ev_mode_fault = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input string req);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      step(req);
   endtask

   task automatic rd(input logic [3:0] a, input string req);
      reg_wr = 1'b0; reg_addr = a;
      step(req);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      m_st = '0; m_mask = '0; m_rthr = 6'd1; m_tthr = 6'd1; m_irq = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R12 irq low while in reset
      check("R12 irq in reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      @(posedge clk);
      // R12 reset values of thresholds, mask and status
      rd(4'd4, "R12 rx threshold");
      rd(4'd5, "R12 tx threshold");
      rd(4'd3, "R12 mask");
      reg_addr = 4'd0; #1;
      check("R12 status", reg_rdata, 32'h0000_0004);

      // R2 event sets sticky, R8 enable mask, R11 irq follows
      ev_rx_over = 1'b1; rd(4'd0, "R2 event pulse");
      rd(4'd0, "R2 overflow held");
      wr(4'd1, 32'hFFFF_FF01, "R8 set mask");
      rd(4'd1, "R8 set reads zero");
      rd(4'd0, "R11 irq on");
      // R4 event and clear together: event wins
      ev_rx_over = 1'b1; wr(4'd0, 32'h0000_0001, "R4 collide");
      rd(4'd0, "R4 still set");
      // R3 write 0 no effect, then write 1 clears
      wr(4'd0, 32'h0000_0000, "R3 zero write");
      rd(4'd0, "R3 held");
      wr(4'd0, 32'hFFFF_FFFF, "R3 clear all");
      rd(4'd0, "R3 cleared");
      // R10 mask read-only
      wr(4'd3, 32'h0000_007F, "R10 write mask addr");
      rd(4'd3, "R10 mask unchanged");
      // R9 disable
      wr(4'd2, 32'h0000_0001, "R9 clear mask");
      rd(4'd2, "R9 clear reads zero");
      rd(4'd3, "R9 mask read");
      // R5 zero rx threshold: always reached; R6 zero tx threshold: never room
      wr(4'd4, 32'h0, "R5 thr zero");
      wr(4'd5, 32'h0, "R6 thr zero");
      rx_level = 6'd0; tx_level = 6'd0; rd(4'd0, "R5 R6 zero thresholds");
      // R5 R6 boundary equal to threshold
      wr(4'd4, 32'd8, "R5 thr 8");
      wr(4'd5, 32'd8, "R6 thr 8");
      rx_level = 6'd8; tx_level = 6'd8; rd(4'd0, "R5 R6 level equals threshold");
      rx_level = 6'd7; tx_level = 6'd7; rd(4'd0, "R5 R6 level below threshold");
      // R7 full flags
      rx_full = 1'b1; tx_full = 1'b1; rd(4'd0, "R7 full flags");
      // R1 unmapped addresses
      wr(4'd7, 32'hFFFF_FFFF, "R1 unmapped write");
      rd(4'd6, "R1 unmapped read");
      rd(4'd15, "R1 unmapped read high");

      // random phase
      for (int i = 0; i < 3000; i++) begin
         rx_level    = 6'($urandom % 33);
         tx_level    = 6'($urandom % 33);
         rx_full     = ($urandom % 4) == 0;
         tx_full     = ($urandom % 4) == 0;
         ev_tx_under = ($urandom % 8) == 0;
         ev_rx_over  = ($urandom % 8) == 0;
         ev_mode_fault = ($urandom % 8) == 0;
         reg_wr    = ($urandom % 2) == 0;
         reg_addr  = 4'($urandom % 8);
         reg_wdata = $urandom;
         if (reg_addr >= 4'd4 && ($urandom % 2) == 0) reg_wdata = $urandom % 34;
         step("R1 R2 R3 R5 R6 R7 R8 R9 random");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule